// File: doc/BRIEF.md
# Internal Data Memory Access Unit

This block holds the 256-byte on-chip data memory of an 8-bit microcontroller core. It accepts one access request per cycle and decodes the address according to the addressing mode that the core's instruction decoder selects. The six modes are direct byte, indirect byte, single bit, working register, stack push and stack pop. The same address range 80H-FFH reaches two separate spaces. A direct access there leaves the block on a special-function-register (SFR) bus. An indirect access there lands in the upper half of the memory.

Bit addresses 00H-7FH fold onto a 16-byte segment starting at 20H. A bit write is a one-cycle read-modify-write, so back-to-back bit writes to the same byte all take effect. Bit addresses 80H-FFH are sent to the SFR bus. In that case the read-modify-write is carried out across the bus within the same cycle.

The block owns the stack pointer. The stack pointer is visible to direct accesses at its SFR address. Push increments it before writing. Pop reads and then decrements it. Read results are registered and appear one cycle after the request.

Top module: `idata_access_unit`

## Requirements
- R1: After reset the stack pointer is 07H, and rdValid, rdData and rdBit are 0.
- R2: The reqMode encoding is 0 direct, 1 indirect, 2 bit, 3 register, 4 push, 5 pop, and 6 and 7 do nothing. For addresses 00H-7FH, direct and indirect accesses reach the same memory byte.
- R3: A direct access at 80H-FFH, other than the stack pointer address, drives sfrAddr with the address. A read asserts sfrRd and returns sfrRdata. A write asserts sfrWr with sfrWdata equal to reqWdata. Memory is left unchanged.
- R4: An indirect access at 80H-FFH reads or writes the upper memory half, and sfrRd and sfrWr stay low.
- R5: A register access with reqAddr[2:0] = r and bankSel = n reaches byte 8n + r.
- R6: A bit access with bit address 00H-7FH reaches byte 20H + address[6:3], at bit position address[2:0]. A bit write changes only that bit.
- R7: Bit writes in consecutive cycles to the same byte all take effect, and a read in the following cycle sees every one of them.
- R8: A bit access with bit address 80H-FFH uses sfrAddr = address with bits [2:0] cleared. A bit write asserts sfrRd and sfrWr in the same cycle, with sfrWdata equal to sfrRdata with only the addressed bit replaced.
- R9: A push first increments the stack pointer and then writes reqWdata at the new value, so the first push after reset lands at 08H.
- R10: A pop returns the byte at the stack pointer and then decrements it. The stack pointer wraps modulo 256.
- R11: A direct access at 81H reads or writes the stack pointer, with sfrRd and sfrWr low.
- R12: A read places its result on rdData and rdBit, with rdValid high, exactly one cycle after the request. rdValid is low in the cycle after any non-read cycle.
- R13: With the stack pointer at or above 80H, a push writes upper memory and asserts no SFR strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqMode | input | 3 | Addressing mode (encoding in R2) |
| reqWrite | input | 1 | Write request (direct, indirect, bit, register) |
| reqAddr | input | 8 | Byte address, bit address, or register index in [2:0] |
| reqWdata | input | 8 | Byte write data and push data |
| reqBit | input | 1 | Bit write value |
| bankSel | input | 2 | Register bank select |
| rdValid | output | 1 | Read result valid |
| rdData | output | 8 | Registered read byte |
| rdBit | output | 1 | Registered read bit |
| sfrRd | output | 1 | SFR bus read strobe |
| sfrWr | output | 1 | SFR bus write strobe |
| sfrAddr | output | 8 | SFR bus address |
| sfrWdata | output | 8 | SFR bus write data |
| sfrRdata | input | 8 | SFR bus read data, sampled in the same cycle |

## Verification
A wrong stack pointer shows up in two places. A direct read of 81H returns it one cycle later. A push or pop that lands on the wrong byte is exposed by a later indirect read. A corrupted memory byte from a bad decode or a wide bit write appears on rdData one cycle after the next read of either alias of that byte. Misrouting between the memory and the SFR bus is visible in the same cycle on sfrRd and sfrWr. It is also visible one cycle later as an upper-memory byte that changed or failed to change.

// File: rtl/idata_pkg.sv
package idata_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int BIT_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    MODE_DIRECT   = 3'd0,
    MODE_INDIRECT = 3'd1,
    MODE_BIT      = 3'd2,
    MODE_REG      = 3'd3,
    MODE_PUSH     = 3'd4,
    MODE_POP      = 3'd5,
    MODE_NONE6    = 3'd6,
    MODE_NONE7    = 3'd7
  } accMode_e;

  typedef struct packed {
    logic              ramWe;
    logic [ADDR_W-1:0] ramAddr;
    logic              sfrSel;
    logic              spSel;
    logic              spWe;
    logic              spInc;
    logic              spDec;
    logic              bitOp;
    logic [BIT_W-1:0]  bitPos;
    logic              rdLoad;
  } ctrlStrobe_t;
endpackage

// File: rtl/idata_ctrl.sv
module idata_ctrl
  import idata_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SP_ADDR  = 8'h81,
  parameter logic [ADDR_W-1:0] BIT_BASE = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  accMode_e          reqMode,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        bankSel,
  input  logic [ADDR_W-1:0] sp,
  output ctrlStrobe_t       strobe,
  output logic              sfrRd,
  output logic              sfrWr,
  output logic [ADDR_W-1:0] sfrAddr
);
  localparam int SEG_W = ADDR_W - 1 - BIT_W;

  logic upperHalf;
  logic spHit;
  logic sfrWe;

  assign upperHalf = reqAddr[ADDR_W-1];
  assign spHit     = (reqAddr == SP_ADDR);

  always_comb begin
    strobe         = '0;
    strobe.ramAddr = reqAddr;
    sfrWe          = 1'b0;
    if (reqValid) begin
      unique case (reqMode)
        MODE_DIRECT: begin
          strobe.rdLoad = !reqWrite;
          if (!upperHalf) begin
            strobe.ramWe = reqWrite;
          end else if (spHit) begin
            strobe.spSel = 1'b1;
            strobe.spWe  = reqWrite;
          end else begin
            strobe.sfrSel = 1'b1;
            sfrWe         = reqWrite;
          end
        end
        MODE_INDIRECT: begin
          strobe.rdLoad = !reqWrite;
          strobe.ramWe  = reqWrite;
        end
        MODE_BIT: begin
          strobe.rdLoad = !reqWrite;
          strobe.bitOp  = 1'b1;
          strobe.bitPos = reqAddr[BIT_W-1:0];
          if (!upperHalf) begin
            strobe.ramAddr = BIT_BASE + ADDR_W'(reqAddr[BIT_W +: SEG_W]);
            strobe.ramWe   = reqWrite;
          end else begin
            strobe.ramAddr = {reqAddr[ADDR_W-1:BIT_W], {BIT_W{1'b0}}};
            strobe.sfrSel  = 1'b1;
            sfrWe          = reqWrite;
          end
        end
        MODE_REG: begin
          strobe.rdLoad  = !reqWrite;
          strobe.ramAddr = ADDR_W'({bankSel, reqAddr[2:0]});
          strobe.ramWe   = reqWrite;
        end
        MODE_PUSH: begin
          strobe.ramAddr = sp + ADDR_W'(1);
          strobe.ramWe   = 1'b1;
          strobe.spInc   = 1'b1;
        end
        MODE_POP: begin
          strobe.ramAddr = sp;
          strobe.rdLoad  = 1'b1;
          strobe.spDec   = 1'b1;
        end
        default: strobe = '0;
      endcase
    end
  end

  assign sfrRd   = strobe.sfrSel && (!sfrWe || strobe.bitOp);
  assign sfrWr   = strobe.sfrSel && sfrWe;
  assign sfrAddr = strobe.ramAddr;

  // Indirect and stack accesses never reach the SFR bus (R4, R13)
  assert_indirect_no_sfr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqMode == MODE_INDIRECT || reqMode == MODE_PUSH || reqMode == MODE_POP))
      |-> (!sfrRd && !sfrWr));

  // Upper bit addresses go out byte-aligned with a read of the host byte (R8)
  assert_sfr_bit_aligned_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == MODE_BIT && upperHalf)
      |-> (sfrAddr[BIT_W-1:0] == '0 && sfrRd));

  // The stack pointer address never leaks onto the bus on a direct access (R11)
  assert_sp_private_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == MODE_DIRECT && spHit) |-> (!sfrRd && !sfrWr));
endmodule

// File: rtl/idata_dpath.sv
module idata_dpath
  import idata_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SP_RESET = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqBit,
  input  logic [DATA_W-1:0] sfrRdata,
  output logic [ADDR_W-1:0] sp,
  output logic [DATA_W-1:0] sfrWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdBit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] readByte;
  logic [DATA_W-1:0] mergedByte;
  logic [DATA_W-1:0] writeByte;

  always_comb begin
    if (strobe.sfrSel)     readByte = sfrRdata;
    else if (strobe.spSel) readByte = sp;
    else                   readByte = mem[strobe.ramAddr];
  end

  always_comb begin
    mergedByte                = readByte;
    mergedByte[strobe.bitPos] = reqBit;
  end

  assign writeByte = strobe.bitOp ? mergedByte : reqWdata;
  assign sfrWdata  = writeByte;

  always_ff @(posedge clk) begin
    if (strobe.ramWe) mem[strobe.ramAddr] <= writeByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sp <= SP_RESET;
    else if (strobe.spWe)  sp <= writeByte;
    else if (strobe.spInc) sp <= sp + ADDR_W'(1);
    else if (strobe.spDec) sp <= sp - ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
      rdBit   <= 1'b0;
    end else begin
      rdValid <= strobe.rdLoad;
      if (strobe.rdLoad) begin
        rdData <= readByte;
        rdBit  <= readByte[strobe.bitPos];
      end
    end
  end

  // A bit write never disturbs more than one bit of its host byte (R6)
  assert_single_bit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ramWe && strobe.bitOp) |-> ($countones(writeByte ^ readByte) <= 1));

  // Push advances the pointer by exactly one (R9)
  assert_push_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.spInc |=> (sp == $past(sp) + ADDR_W'(1)));

  // Pop retreats the pointer by exactly one, wrapping (R10)
  assert_pop_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.spDec |=> (sp == $past(sp) - ADDR_W'(1)));
endmodule

// File: rtl/idata_access_unit.sv
module idata_access_unit
  import idata_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SP_ADDR  = 8'h81,
  parameter logic [ADDR_W-1:0] SP_RESET = 8'h07,
  parameter logic [ADDR_W-1:0] BIT_BASE = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqMode,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqBit,
  input  logic [1:0]        bankSel,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdBit,
  output logic              sfrRd,
  output logic              sfrWr,
  output logic [ADDR_W-1:0] sfrAddr,
  output logic [DATA_W-1:0] sfrWdata,
  input  logic [DATA_W-1:0] sfrRdata
);
  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] sp;

  idata_ctrl #(
    .SP_ADDR  (SP_ADDR),
    .BIT_BASE (BIT_BASE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqMode  (accMode_e'(reqMode)),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .bankSel  (bankSel),
    .sp       (sp),
    .strobe   (strobe),
    .sfrRd    (sfrRd),
    .sfrWr    (sfrWr),
    .sfrAddr  (sfrAddr)
  );

  idata_dpath #(
    .SP_RESET (SP_RESET)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqWdata (reqWdata),
    .reqBit   (reqBit),
    .sfrRdata (sfrRdata),
    .sp       (sp),
    .sfrWdata (sfrWdata),
    .rdValid  (rdValid),
    .rdData   (rdData),
    .rdBit    (rdBit)
  );

  // A valid result only ever follows a request one cycle earlier (R12)
  assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(reqValid));
endmodule

// File: tb/idata_access_unit_bench.sv
module idata_access_unit_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqMode = 3'd0;
  logic       reqWrite = 1'b0;
  logic [7:0] reqAddr = 8'h00;
  logic [7:0] reqWdata = 8'h00;
  logic       reqBit = 1'b0;
  logic [1:0] bankSel = 2'd0;
  logic       rdValid;
  logic [7:0] rdData;
  logic       rdBit;
  logic       sfrRd;
  logic       sfrWr;
  logic [7:0] sfrAddr;
  logic [7:0] sfrWdata;
  logic [7:0] sfrRdata;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  assign sfrRdata = sfrAddr ^ 8'h5A;

  idata_access_unit u_idata_access_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBit(reqBit),
    .bankSel(bankSel), .rdValid(rdValid), .rdData(rdData), .rdBit(rdBit),
    .sfrRd(sfrRd), .sfrWr(sfrWr), .sfrAddr(sfrAddr), .sfrWdata(sfrWdata),
    .sfrRdata(sfrRdata)
  );

  typedef struct packed {
    logic [2:0] mode;
    logic       wr;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic       bitv;
    logic [1:0] bank;
    logic [1:0] chk;   // 0 none, 1 byte, 2 bit
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b1, 8'h30, 8'h11, 1'b0, 2'd0, 2'd0, 8'h00, 4'd2},  // R2 direct write
    '{3'd1, 1'b0, 8'h30, 8'h00, 1'b0, 2'd0, 2'd1, 8'h11, 4'd2},  // R2 indirect alias
    '{3'd1, 1'b1, 8'h45, 8'h22, 1'b0, 2'd0, 2'd0, 8'h00, 4'd2},
    '{3'd0, 1'b0, 8'h45, 8'h00, 1'b0, 2'd0, 2'd1, 8'h22, 4'd2},  // R2
    '{3'd1, 1'b1, 8'hC0, 8'h33, 1'b0, 2'd0, 2'd0, 8'h00, 4'd4},  // R4 upper write
    '{3'd1, 1'b0, 8'hC0, 8'h00, 1'b0, 2'd0, 2'd1, 8'h33, 4'd4},  // R4
    '{3'd0, 1'b0, 8'hC0, 8'h00, 1'b0, 2'd0, 2'd1, 8'h9A, 4'd3},  // R3 bus read
    '{3'd0, 1'b1, 8'hC0, 8'h77, 1'b0, 2'd0, 2'd0, 8'h00, 4'd3},
    '{3'd1, 1'b0, 8'hC0, 8'h00, 1'b0, 2'd0, 2'd1, 8'h33, 4'd3},  // R3 memory kept
    '{3'd3, 1'b1, 8'h05, 8'h44, 1'b0, 2'd2, 2'd0, 8'h00, 4'd5},  // R5 bank 2 r5
    '{3'd0, 1'b0, 8'h15, 8'h00, 1'b0, 2'd0, 2'd1, 8'h44, 4'd5},
    '{3'd0, 1'b1, 8'h0B, 8'h66, 1'b0, 2'd0, 2'd0, 8'h00, 4'd5},
    '{3'd3, 1'b0, 8'h03, 8'h00, 1'b0, 2'd1, 2'd1, 8'h66, 4'd5},  // R5 bank 1 r3
    '{3'd0, 1'b1, 8'h2C, 8'h00, 1'b0, 2'd0, 2'd0, 8'h00, 4'd6},
    '{3'd2, 1'b1, 8'h63, 8'h00, 1'b1, 2'd0, 2'd0, 8'h00, 4'd6},  // R6 set bit
    '{3'd0, 1'b0, 8'h2C, 8'h00, 1'b0, 2'd0, 2'd1, 8'h08, 4'd6},
    '{3'd2, 1'b0, 8'h63, 8'h00, 1'b0, 2'd0, 2'd2, 8'h01, 4'd6},
    '{3'd2, 1'b0, 8'h64, 8'h00, 1'b0, 2'd0, 2'd2, 8'h00, 4'd6},
    '{3'd0, 1'b1, 8'h2C, 8'hFF, 1'b0, 2'd0, 2'd0, 8'h00, 4'd6},
    '{3'd2, 1'b1, 8'h60, 8'h00, 1'b0, 2'd0, 2'd0, 8'h00, 4'd6},  // R6 clear bit
    '{3'd0, 1'b0, 8'h2C, 8'h00, 1'b0, 2'd0, 2'd1, 8'hFE, 4'd6}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] m, input logic w, input logic [7:0] a,
                       input logic [7:0] d, input logic b, input logic [1:0] bk);
    @(negedge clk);
    reqValid = 1'b1; reqMode = m; reqWrite = w; reqAddr = a;
    reqWdata = d; reqBit = b; bankSel = bk;
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    #1;
  endtask

  task automatic readByte(input logic [2:0] m, input logic [7:0] a, input string tag,
                          input logic [7:0] exp);
    issue(m, 1'b0, a, 8'h00, 1'b0, 2'd0);
    idle();
    check(tag, rdData, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 rdValid", {7'd0, rdValid}, 8'h00);
    check("R1 rdData", rdData, 8'h00);
    check("R1 rdBit", {7'd0, rdBit}, 8'h00);
    // R1 / R11 stack pointer readable at its own address, off the bus
    issue(3'd0, 1'b0, 8'h81, 8'h00, 1'b0, 2'd0);
    #1;
    check("R11 sfrRd low", {7'd0, sfrRd}, 8'h00);
    check("R12 rdValid before", {7'd0, rdValid}, 8'h00);
    idle();
    check("R1 sp reset", rdData, 8'h07);
    check("R12 rdValid after", {7'd0, rdValid}, 8'h01);
    idle();
    check("R12 rdValid drop", {7'd0, rdValid}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].mode, VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].bitv, VECS[i].bank);
      idle();
      if (VECS[i].chk == 2'd1)
        check($sformatf("R%0d vec%0d", VECS[i].req, i), rdData, VECS[i].exp);
      else if (VECS[i].chk == 2'd2)
        check($sformatf("R%0d vec%0d", VECS[i].req, i), {7'd0, rdBit}, VECS[i].exp);
    end

    // R3 bus write strobes
    issue(3'd0, 1'b1, 8'hC0, 8'h77, 1'b0, 2'd0);
    #1;
    check("R3 sfrWr", {7'd0, sfrWr}, 8'h01);
    check("R3 sfrRd", {7'd0, sfrRd}, 8'h00);
    check("R3 sfrAddr", sfrAddr, 8'hC0);
    check("R3 sfrWdata", sfrWdata, 8'h77);
    // R4 indirect upper keeps bus quiet
    issue(3'd1, 1'b1, 8'hC0, 8'h55, 1'b0, 2'd0);
    #1;
    check("R4 strobes", {6'd0, sfrRd, sfrWr}, 8'h00);
    idle();
    readByte(3'd1, 8'hC0, "R4 upper", 8'h55);

    // R7 consecutive bit writes then immediate read
    issue(3'd0, 1'b1, 8'h2D, 8'h00, 1'b0, 2'd0);
    issue(3'd2, 1'b1, 8'h68, 8'h00, 1'b1, 2'd0);
    issue(3'd2, 1'b1, 8'h6F, 8'h00, 1'b1, 2'd0);
    issue(3'd0, 1'b0, 8'h2D, 8'h00, 1'b0, 2'd0);
    idle();
    check("R7 merged", rdData, 8'h81);

    // R8 bit write on the bus: byte 98H reads C2H, set bit 3 -> CAH
    issue(3'd2, 1'b1, 8'h9B, 8'h00, 1'b1, 2'd0);
    #1;
    check("R8 sfrAddr", sfrAddr, 8'h98);
    check("R8 strobes", {6'd0, sfrRd, sfrWr}, 8'h03);
    check("R8 sfrWdata", sfrWdata, 8'hCA);
    issue(3'd2, 1'b0, 8'h9E, 8'h00, 1'b0, 2'd0);
    idle();
    check("R8 bit read", {7'd0, rdBit}, 8'h01);

    // R9 push pre-increment
    issue(3'd4, 1'b0, 8'h00, 8'hAA, 1'b0, 2'd0);
    issue(3'd4, 1'b0, 8'h00, 8'hBB, 1'b0, 2'd0);
    idle();
    readByte(3'd1, 8'h08, "R9 first push", 8'hAA);
    readByte(3'd1, 8'h09, "R9 second push", 8'hBB);
    readByte(3'd0, 8'h81, "R9 sp", 8'h09);

    // R10 pop order and wrap
    issue(3'd5, 1'b0, 8'h00, 8'h00, 1'b0, 2'd0);
    idle();
    check("R10 pop1", rdData, 8'hBB);
    issue(3'd5, 1'b0, 8'h00, 8'h00, 1'b0, 2'd0);
    idle();
    check("R10 pop2", rdData, 8'hAA);
    readByte(3'd0, 8'h81, "R10 sp back", 8'h07);
    issue(3'd0, 1'b1, 8'h81, 8'h00, 1'b0, 2'd0);   // R11 write stack pointer
    #1;
    check("R11 write off bus", {6'd0, sfrRd, sfrWr}, 8'h00);
    issue(3'd1, 1'b1, 8'h00, 8'h5C, 1'b0, 2'd0);
    issue(3'd5, 1'b0, 8'h00, 8'h00, 1'b0, 2'd0);
    idle();
    check("R10 pop at 00", rdData, 8'h5C);
    readByte(3'd0, 8'h81, "R10 wrap", 8'hFF);

    // R13 stack in upper memory
    issue(3'd0, 1'b1, 8'h81, 8'h90, 1'b0, 2'd0);
    issue(3'd4, 1'b0, 8'h00, 8'hAB, 1'b0, 2'd0);
    #1;
    check("R13 push strobes", {6'd0, sfrRd, sfrWr}, 8'h00);
    idle();
    readByte(3'd1, 8'h91, "R13 upper stack", 8'hAB);
    readByte(3'd0, 8'h81, "R13 sp", 8'h91);

    // R2 unused mode codes do nothing
    issue(3'd6, 1'b1, 8'h30, 8'hEE, 1'b0, 2'd0);
    idle();
    check("R2 no-op valid", {7'd0, rdValid}, 8'h00);
    readByte(3'd1, 8'h30, "R2 no-op kept", 8'h11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule